// File: doc/BRIEF.md
# Clock Discipline Mode Controller

This block sits in front of a clock-discipline loop filter and decides, for every new clock offset measurement, what the local clock should do with it. It can step the time, load a frequency estimate, apply a normal phase-locked update, or drop the measurement as a spike. A measurement that is far too large to trust raises a latched panic, and all later updates stop.

Each valid sample is graded by two tests. The step test asks whether the offset magnitude is above 128 ms. The stepout test asks whether more than 900 seconds have gone by since the last accepted update. The two results form a two-bit event code, and that code drives a six-mode machine. The machine sets the clock on the first sample. It then measures or trusts the frequency, and afterwards it keeps ignoring large offsets until they have persisted past the stepout window. Elapsed time is kept internally from a once-per-second tick, and the count clears whenever an update is accepted.

Top module: `clock_mode_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises, mode_o is 0 (unset) and step_time_o, set_freq_o, pll_update_o and panic_o are all low.
- R2: A sample counts as a step only when its offset magnitude is strictly above 128 000 000 ns. An offset of exactly ±128 000 000 ns is not a step.
- R3: Stepout holds only when more than 900 second ticks have been counted since the last accepted update, that is, after 901 ticks. Any sample that issues a command is an accepted update and clears the count. When a tick and an accepted update fall in the same cycle, the clear wins.
- R4: A sample whose offset magnitude is strictly above 1 000 000 000 000 ns sets panic_o. panic_o stays high until reset, that sample and every later one issue no command, and mode_o no longer changes. A magnitude of exactly 10^12 ns does not cause panic.
- R5: In mode 0 (unset), any sample pulses step_time_o. The mode then becomes 1 (warm) when freq_saved_i is high, and 2 (measure) when it is low.
- R6: In mode 2 (measure), a sample without stepout issues nothing and the mode holds. Stepout without step pulses set_freq_o, and stepout with step pulses both step_time_o and set_freq_o. In both stepout cases the mode moves to 4 (locked).
- R7: In mode 1 (warm), a non-step sample pulses pll_update_o and moves to 4 (locked). A step sample pulses step_time_o and moves to 3 (settle).
- R8: In mode 3 (settle), a non-step sample pulses pll_update_o and moves to 4 (locked). A step sample pulses step_time_o and the mode stays 3.
- R9: In mode 4 (locked), a non-step sample pulses pll_update_o and the mode stays 4. A step without stepout issues nothing and moves to 5 (spike). A step with stepout pulses step_time_o only and the mode stays 4.
- R10: In mode 5 (spike), a non-step sample pulses pll_update_o and returns to 4. A step without stepout issues nothing and the mode stays 5. A step with stepout pulses step_time_o and set_freq_o together and returns to 4.
- R11: Commands appear as one-cycle pulses in the cycle after the valid sample, and no command appears without a valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_valid_i | input | 1 | Offset sample strobe |
| offset_i | input | 64 | Signed clock offset in nanoseconds |
| sec_tick_i | input | 1 | One pulse per elapsed second |
| freq_saved_i | input | 1 | A stored frequency estimate is available |
| step_time_o | output | 1 | Command: step the clock time |
| set_freq_o | output | 1 | Command: load the frequency |
| pll_update_o | output | 1 | Command: normal phase-locked update |
| panic_o | output | 1 | Latched panic, offset beyond sanity limit |
| mode_o | output | 3 | Current mode (0 unset … 5 spike) |

## Verification
The collision that matters is a second tick landing in the same cycle as an accepted update, which is a clear and an increment on the elapsed count at once. The bench provokes it by issuing the locking sample with sec_tick_i high. It then judges the result through the ports alone. After 900 further ticks a large offset must still be treated as a spike. After one more tick the same offset must produce a combined time-and-frequency set, which shows that the colliding tick was discarded.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  typedef enum logic [2:0] {
    ST_UNSET   = 3'd0,
    ST_WARM    = 3'd1,
    ST_MEASURE = 3'd2,
    ST_SETTLE  = 3'd3,
    ST_LOCKED  = 3'd4,
    ST_SPIKE   = 3'd5
  } mode_e;

  // bit0 = step, bit1 = stepout
  typedef enum logic [1:0] {
    EV_QUIET      = 2'd0,
    EV_STEP       = 2'd1,
    EV_STALE      = 2'd2,
    EV_STALE_STEP = 2'd3
  } evt_e;
endpackage

// File: rtl/cdm_classify.sv
module cdm_classify
  import cdm_pkg::*;
#(
  parameter int              OFS_W    = 64,
  parameter longint unsigned STEP_NS  = 64'd128_000_000,
  parameter longint unsigned PANIC_NS = 64'd1_000_000_000_000
) (
  input  logic signed [OFS_W-1:0] offset_i,
  input  logic                    stepout_i,
  output evt_e                    event_o,
  output logic                    panic_o
);
  logic [OFS_W-1:0] mag;
  logic             is_step;

  assign mag     = offset_i[OFS_W-1] ? (~offset_i + 1'b1) : offset_i;
  assign is_step = mag > OFS_W'(STEP_NS);
  assign panic_o = mag > OFS_W'(PANIC_NS);
  assign event_o = evt_e'({stepout_i, is_step});
endmodule

// File: rtl/cdm_elapsed.sv
module cdm_elapsed #(
  parameter int SEC_W     = 32,
  parameter int STEPOUT_S = 900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic stepout_o
);
  logic [SEC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;  // clear beats tick
    else if (tick_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign stepout_o = cnt_q > SEC_W'(STEPOUT_S);

  // R3
  clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !stepout_o);
endmodule

// File: rtl/cdm_fsm.sv
module cdm_fsm
  import cdm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  evt_e       event_i,
  input  logic       panic_i,
  input  logic       freq_saved_i,
  output logic       accept_o,
  output logic       step_o,
  output logic       freq_o,
  output logic       pll_o,
  output logic       panic_o,
  output logic [2:0] mode_o
);
  mode_e mode_q, mode_d;
  logic  panic_q;
  logic  step_q, freq_q, pll_q;
  logic  do_step, do_freq, do_pll;
  logic  active;

  assign active = valid_i && !panic_q && !panic_i;

  always_comb begin
    mode_d  = mode_q;
    do_step = 1'b0;
    do_freq = 1'b0;
    do_pll  = 1'b0;
    unique case (mode_q)
      ST_UNSET: begin
        do_step = 1'b1;
        mode_d  = freq_saved_i ? ST_WARM : ST_MEASURE;
      end
      ST_WARM, ST_SETTLE: begin
        if (event_i[0]) begin
          do_step = 1'b1;
          mode_d  = ST_SETTLE;
        end else begin
          do_pll  = 1'b1;
          mode_d  = ST_LOCKED;
        end
      end
      ST_MEASURE: begin
        if (event_i[1]) begin
          do_freq = 1'b1;
          do_step = event_i[0];
          mode_d  = ST_LOCKED;
        end
      end
      ST_LOCKED: begin
        unique case (event_i)
          EV_STEP:       mode_d  = ST_SPIKE;
          EV_STALE_STEP: do_step = 1'b1;
          default:       do_pll  = 1'b1;
        endcase
      end
      ST_SPIKE: begin
        unique case (event_i)
          EV_STEP: mode_d = ST_SPIKE;
          EV_STALE_STEP: begin
            do_step = 1'b1;
            do_freq = 1'b1;
            mode_d  = ST_LOCKED;
          end
          default: begin
            do_pll = 1'b1;
            mode_d = ST_LOCKED;
          end
        endcase
      end
      default: mode_d = ST_UNSET;
    endcase
  end

  assign accept_o = active && (do_step || do_freq || do_pll);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= ST_UNSET;
      panic_q <= 1'b0;
      step_q  <= 1'b0;
      freq_q  <= 1'b0;
      pll_q   <= 1'b0;
    end else begin
      step_q <= active && do_step;
      freq_q <= active && do_freq;
      pll_q  <= active && do_pll;
      if (valid_i && panic_i) panic_q <= 1'b1;
      if (active)             mode_q  <= mode_d;
    end
  end

  assign step_o  = step_q;
  assign freq_o  = freq_q;
  assign pll_o   = pll_q;
  assign panic_o = panic_q;
  assign mode_o  = mode_q;

  // R4
  panic_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panic_q |=> panic_q);
  // R4
  panic_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(panic_q) |-> !(step_q || freq_q || pll_q));
  // R5
  first_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == ST_UNSET && mode_q != ST_UNSET) |-> step_q);
  // R9
  spike_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == ST_SPIKE && $past(mode_q) == ST_LOCKED) |-> !(step_q || freq_q || pll_q));
  // R11
  cmd_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q || freq_q || pll_q) |-> $past(valid_i));
endmodule

// File: rtl/clock_mode_ctrl.sv
module clock_mode_ctrl
  import cdm_pkg::*;
#(
  parameter int              OFS_W     = 64,
  parameter int              SEC_W     = 32,
  parameter longint unsigned STEP_NS   = 64'd128_000_000,
  parameter longint unsigned PANIC_NS  = 64'd1_000_000_000_000,
  parameter int              STEPOUT_S = 900
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_valid_i,
  input  logic signed [OFS_W-1:0] offset_i,
  input  logic                    sec_tick_i,
  input  logic                    freq_saved_i,
  output logic                    step_time_o,
  output logic                    set_freq_o,
  output logic                    pll_update_o,
  output logic                    panic_o,
  output logic [2:0]              mode_o
);
  evt_e evt;
  logic stepout, too_big, accept;

  cdm_elapsed #(.SEC_W(SEC_W), .STEPOUT_S(STEPOUT_S)) u_elapsed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sec_tick_i),
    .clear_i   (accept),
    .stepout_o (stepout)
  );

  cdm_classify #(.OFS_W(OFS_W), .STEP_NS(STEP_NS), .PANIC_NS(PANIC_NS)) u_classify (
    .offset_i  (offset_i),
    .stepout_i (stepout),
    .event_o   (evt),
    .panic_o   (too_big)
  );

  cdm_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (sample_valid_i),
    .event_i      (evt),
    .panic_i      (too_big),
    .freq_saved_i (freq_saved_i),
    .accept_o     (accept),
    .step_o       (step_time_o),
    .freq_o       (set_freq_o),
    .pll_o        (pll_update_o),
    .panic_o      (panic_o),
    .mode_o       (mode_o)
  );
endmodule

// File: tb/clock_mode_ctrl_test.sv
module clock_mode_ctrl_test;
  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid = 1'b0;
  logic signed [63:0] ofs = '0;
  logic               tick = 1'b0;
  logic               saved = 1'b0;
  logic               st, fr, pl, pn;
  logic [2:0]         md;
  int                 checks = 0;
  int                 errors = 0;

  always #10 clk = ~clk;

  clock_mode_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(valid), .offset_i(ofs),
    .sec_tick_i(tick), .freq_saved_i(saved), .step_time_o(st),
    .set_freq_o(fr), .pll_update_o(pl), .panic_o(pn), .mode_o(md)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // outputs as {step,freq,pll,panic} plus mode
  task automatic expect_out(input string req, input logic [3:0] cmd, input int mode);
    chk(req, "step/freq/pll/panic", longint'({st, fr, pl, pn}), longint'(cmd));
    chk(req, "mode", longint'(md), longint'(mode));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic send(input logic signed [63:0] o, input logic tk);
    @(negedge clk);
    valid = 1'b1; ofs = o; tick = tk;
    @(negedge clk);
    valid = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic go_locked();
    do_reset(); saved = 1'b1;
    send(64'sd0, 1'b0);
    send(64'sd0, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_out("R1", 4'b0000, 0);
    do_reset();
    @(negedge clk);
    expect_out("R1", 4'b0000, 0);
  endtask

  task automatic t_unset();
    do_reset(); saved = 1'b1;
    send(64'sd5_000_000, 1'b0);
    expect_out("R5", 4'b1000, 1);
    do_reset(); saved = 1'b0;
    send(64'sd0, 1'b0);
    expect_out("R5", 4'b1000, 2);
    @(negedge clk);
    expect_out("R11", 4'b0000, 2);
  endtask

  task automatic t_measure();
    do_reset(); saved = 1'b0;
    send(64'sd0, 1'b0);
    send(64'sd200_000_000, 1'b0);
    expect_out("R6", 4'b0000, 2);
    ticks(901);
    expect_out("R11", 4'b0000, 2);
    send(64'sd0, 1'b0);
    expect_out("R6", 4'b0100, 4);
    do_reset();
    send(64'sd0, 1'b0);
    ticks(901);
    send(-64'sd300_000_000, 1'b0);
    expect_out("R6", 4'b1100, 4);
    @(negedge clk);
    expect_out("R11", 4'b0000, 4);
  endtask

  task automatic t_warm_settle();
    do_reset(); saved = 1'b1;
    send(64'sd0, 1'b0);
    send(64'sd200_000_000, 1'b0);
    expect_out("R7", 4'b1000, 3);
    send(-64'sd200_000_000, 1'b0);
    expect_out("R8", 4'b1000, 3);
    send(64'sd1_000_000, 1'b0);
    expect_out("R8", 4'b0010, 4);
    do_reset();
    send(64'sd0, 1'b0);
    send(64'sd0, 1'b0);
    expect_out("R7", 4'b0010, 4);
  endtask

  task automatic t_locked_spike();
    go_locked();
    send(64'sd1_000_000, 1'b0);
    expect_out("R9", 4'b0010, 4);
    send(-64'sd500_000_000, 1'b0);
    expect_out("R9", 4'b0000, 5);
    send(64'sd200_000_000, 1'b0);
    expect_out("R10", 4'b0000, 5);
    send(64'sd2_000_000, 1'b0);
    expect_out("R10", 4'b0010, 4);
    send(-64'sd200_000_000, 1'b0);
    ticks(901);
    send(64'sd300_000_000, 1'b0);
    expect_out("R10", 4'b1100, 4);
    ticks(901);
    send(64'sd400_000_000, 1'b0);
    expect_out("R9", 4'b1000, 4);
    send(-64'sd200_000_000, 1'b0);
    ticks(901);
    send(64'sd1_000_000, 1'b0);
    expect_out("R10", 4'b0010, 4);
  endtask

  task automatic t_threshold();
    go_locked();
    send(64'sd128_000_000, 1'b0);
    expect_out("R2", 4'b0010, 4);
    send(-64'sd128_000_000, 1'b0);
    expect_out("R2", 4'b0010, 4);
    send(64'sd128_000_001, 1'b0);
    expect_out("R2", 4'b0000, 5);
  endtask

  task automatic t_collision();
    do_reset(); saved = 1'b1;
    send(64'sd0, 1'b0);
    send(64'sd0, 1'b1);   // accept and tick together
    expect_out("R3", 4'b0010, 4);
    ticks(900);
    send(64'sd200_000_000, 1'b0);
    expect_out("R3", 4'b0000, 5);
    ticks(1);
    send(64'sd200_000_000, 1'b0);
    expect_out("R3", 4'b1100, 4);
  endtask

  task automatic t_panic();
    go_locked();
    send(64'sd1_000_000_000_000, 1'b0);
    expect_out("R4", 4'b0000, 5);
    send(-64'sd1_000_000_000_001, 1'b0);
    expect_out("R4", 4'b0001, 5);
    send(64'sd0, 1'b0);
    expect_out("R4", 4'b0001, 5);
    do_reset(); saved = 1'b0;
    send(64'sd2_000_000_000_000, 1'b0);
    expect_out("R4", 4'b0001, 0);
    do_reset();
    @(negedge clk);
    expect_out("R1", 4'b0000, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_unset();
    t_measure();
    t_warm_settle();
    t_locked_spike();
    t_threshold();
    t_collision();
    t_panic();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule